// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 15-bit virtual address into a 12-bit physical address. It does this by walking a two-level page table that sits in byte-wide physical memory. It then fetches the data byte stored at the resulting physical address. Pages are 32 bytes. A table entry at either level is one byte: a valid flag in bit 7 sits above a 7-bit page number in bits 6:0.

A request is taken only while the walker is idle. The walker reads the directory entry, then the second-level entry, then the data byte. It uses a synchronous read port that returns data one cycle after the read strobe. When the walk ends, the block raises a single-cycle completion strobe. A two-bit fault code reports whether the walk succeeded or at which level it stopped. The physical address and the data byte are reported with it.

Top module: `pt_walker`

## Requirements
- R1: After reset, `busy`, `done` and `mem_rd_en` are 0 and `fault` is 00.
- R2: `req_vaddr` and `dir_base` are captured in the clock cycle where `req_valid` is high and the walker is idle. In the cycle right after that, the first read is issued at byte address {dir_base, vaddr[14:10]}.
- R3: Entries at both levels follow one format: bit 7 set means valid, and bits 6:0 hold a page or frame number.
- R4: A valid directory entry leads to a second read at address {entry[6:0], vaddr[9:5]}. This read is issued two cycles after the first read.
- R5: A valid table entry leads to a third read at address {entry[6:0], vaddr[4:0]}. That same value is reported on `paddr`, and the byte returned by the read is reported on `rdata`.
- R6: An invalid directory entry ends the walk after exactly one read. `done` rises two cycles after the accepting edge, with `fault` = 01, and `paddr` and `rdata` = 0.
- R7: An invalid table entry ends the walk after exactly two reads. `done` rises four cycles after the accepting edge, with `fault` = 10, and `paddr` and `rdata` = 0.
- R8: A successful walk makes exactly three reads. `done` rises six cycles after the accepting edge, with `fault` = 00.
- R9: `done` is high for exactly one cycle per walk.
- R10: A `req_valid` that arrives while `busy` is high is ignored. Neither the addresses of the walk in progress nor its result change.
- R11: `fault`, `paddr` and `rdata` keep their values after `done` until the next walk completes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| dir_base | input | 7 | Page number holding the directory, sampled at accept |
| req_valid | input | 1 | Request strobe |
| req_vaddr | input | 15 | Virtual address to translate |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_addr | output | 12 | Memory byte address |
| mem_rdata | input | 8 | Read data, valid the cycle after the strobe |
| busy | output | 1 | Walk in progress |
| done | output | 1 | One-cycle completion strobe |
| fault | output | 2 | 00 success, 01 directory fault, 10 table fault |
| paddr | output | 12 | Translated physical address |
| rdata | output | 8 | Data byte at the physical address |

## Verification
The bench fills memory with random bytes, so about half of all entries at each level are invalid. A software walk predicts every read address, the completion cycle and the result. It targets a fault at each level separately. A design that skipped the fault check, or checked the wrong bit, would issue extra reads and report a wrong code or a nonzero address. It also sends requests while a walk is running, to catch a walker that re-latches the address mid-walk and so reads the wrong entries. It also confirms that results stay stable after completion, which catches results being cleared once `done` drops.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_PDE_RD = 3'd1,
        ST_PDE_CK = 3'd2,
        ST_PTE_RD = 3'd3,
        ST_PTE_CK = 3'd4,
        ST_DAT_RD = 3'd5,
        ST_DAT_CK = 3'd6
    } walk_st_e;

    localparam logic [1:0] FLT_NONE = 2'b00;
    localparam logic [1:0] FLT_DIR  = 2'b01;
    localparam logic [1:0] FLT_TBL  = 2'b10;

endpackage

// File: rtl/pt_entry_dec.sv
module pt_entry_dec #(
    parameter int PG_W = 7
) (
    input  logic [PG_W:0]   entry,
    output logic            ent_vld,
    output logic [PG_W-1:0] ent_pg
);
    // Valid flag is the most significant bit, page number below it.
    assign ent_vld = entry[PG_W];
    assign ent_pg  = entry[PG_W-1:0];
endmodule

// File: rtl/pt_addr_sel.sv
module pt_addr_sel
    import pt_walker_pkg::*;
#(
    parameter int OFF_W = 5,
    parameter int PG_W  = 7,
    localparam int VA_W = 3 * OFF_W,
    localparam int PA_W = PG_W + OFF_W
) (
    input  walk_st_e          st,
    input  logic [PG_W-1:0]   base,
    input  logic [PG_W-1:0]   pg,
    input  logic [VA_W-1:0]   va,
    output logic              rd_en,
    output logic [PA_W-1:0]   addr
);
    logic [OFF_W-1:0] idx_dir, idx_tbl, idx_off;

    assign idx_dir = va[VA_W-1 -: OFF_W];
    assign idx_tbl = va[2*OFF_W-1 -: OFF_W];
    assign idx_off = va[OFF_W-1:0];

    always_comb begin
        rd_en = 1'b0;
        addr  = '0;
        unique case (st)
            ST_PDE_RD: begin
                rd_en = 1'b1;
                addr  = {base, idx_dir};
            end
            ST_PTE_RD: begin
                rd_en = 1'b1;
                addr  = {pg, idx_tbl};
            end
            ST_DAT_RD: begin
                rd_en = 1'b1;
                addr  = {pg, idx_off};
            end
            default: ;
        endcase
    end
endmodule

// File: rtl/pt_walk_fsm.sv
module pt_walk_fsm
    import pt_walker_pkg::*;
#(
    parameter int OFF_W = 5,
    parameter int PG_W  = 7,
    localparam int VA_W = 3 * OFF_W,
    localparam int PA_W = PG_W + OFF_W,
    localparam int DW   = PG_W + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            req_valid,
    input  logic [VA_W-1:0] req_vaddr,
    input  logic [PG_W-1:0] dir_base,
    input  logic            ent_vld,
    input  logic [PG_W-1:0] ent_pg,
    input  logic [DW-1:0]   mem_rdata,
    output walk_st_e        st_q,
    output logic [VA_W-1:0] va_q,
    output logic [PG_W-1:0] base_q,
    output logic [PG_W-1:0] pg_q,
    output logic            done_q,
    output logic [1:0]      fault_q,
    output logic [PA_W-1:0] paddr_q,
    output logic [DW-1:0]   data_q
);
    typedef struct packed {
        walk_st_e        st;
        logic [VA_W-1:0] va;
        logic [PG_W-1:0] base;
        logic [PG_W-1:0] pg;
        logic            done;
        logic [1:0]      fault;
        logic [PA_W-1:0] paddr;
        logic [DW-1:0]   data;
    } walk_t;

    walk_t r_d, r_q;

    always_comb begin
        r_d      = r_q;
        r_d.done = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.st   = ST_PDE_RD;
                    r_d.va   = req_vaddr;
                    r_d.base = dir_base;
                end
            end
            ST_PDE_RD: r_d.st = ST_PDE_CK;
            ST_PDE_CK: begin
                if (ent_vld) begin
                    r_d.pg = ent_pg;
                    r_d.st = ST_PTE_RD;
                end else begin
                    r_d.st    = ST_IDLE;
                    r_d.done  = 1'b1;
                    r_d.fault = FLT_DIR;
                    r_d.paddr = '0;
                    r_d.data  = '0;
                end
            end
            ST_PTE_RD: r_d.st = ST_PTE_CK;
            ST_PTE_CK: begin
                if (ent_vld) begin
                    r_d.pg = ent_pg;
                    r_d.st = ST_DAT_RD;
                end else begin
                    r_d.st    = ST_IDLE;
                    r_d.done  = 1'b1;
                    r_d.fault = FLT_TBL;
                    r_d.paddr = '0;
                    r_d.data  = '0;
                end
            end
            ST_DAT_RD: r_d.st = ST_DAT_CK;
            ST_DAT_CK: begin
                r_d.st    = ST_IDLE;
                r_d.done  = 1'b1;
                r_d.fault = FLT_NONE;
                r_d.paddr = {r_q.pg, r_q.va[OFF_W-1:0]};
                r_d.data  = mem_rdata;
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign st_q    = r_q.st;
    assign va_q    = r_q.va;
    assign base_q  = r_q.base;
    assign pg_q    = r_q.pg;
    assign done_q  = r_q.done;
    assign fault_q = r_q.fault;
    assign paddr_q = r_q.paddr;
    assign data_q  = r_q.data;
endmodule

// File: rtl/pt_walker.sv
module pt_walker
    import pt_walker_pkg::*;
#(
    parameter int OFF_W = 5,
    parameter int PG_W  = 7,
    localparam int VA_W = 3 * OFF_W,
    localparam int PA_W = PG_W + OFF_W,
    localparam int DW   = PG_W + 1
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PG_W-1:0] dir_base,
    input  logic            req_valid,
    input  logic [VA_W-1:0] req_vaddr,
    output logic            mem_rd_en,
    output logic [PA_W-1:0] mem_addr,
    input  logic [DW-1:0]   mem_rdata,
    output logic            busy,
    output logic            done,
    output logic [1:0]      fault,
    output logic [PA_W-1:0] paddr,
    output logic [DW-1:0]   rdata
);
    walk_st_e        st_q;
    logic [VA_W-1:0] va_q;
    logic [PG_W-1:0] base_q;
    logic [PG_W-1:0] pg_q;
    logic            ent_vld;
    logic [PG_W-1:0] ent_pg;

    pt_entry_dec #(.PG_W(PG_W)) u_dec (
        .entry   (mem_rdata),
        .ent_vld (ent_vld),
        .ent_pg  (ent_pg)
    );

    pt_walk_fsm #(.OFF_W(OFF_W), .PG_W(PG_W)) u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .req_valid (req_valid),
        .req_vaddr (req_vaddr),
        .dir_base  (dir_base),
        .ent_vld   (ent_vld),
        .ent_pg    (ent_pg),
        .mem_rdata (mem_rdata),
        .st_q      (st_q),
        .va_q      (va_q),
        .base_q    (base_q),
        .pg_q      (pg_q),
        .done_q    (done),
        .fault_q   (fault),
        .paddr_q   (paddr),
        .data_q    (rdata)
    );

    pt_addr_sel #(.OFF_W(OFF_W), .PG_W(PG_W)) u_sel (
        .st    (st_q),
        .base  (base_q),
        .pg    (pg_q),
        .va    (va_q),
        .rd_en (mem_rd_en),
        .addr  (mem_addr)
    );

    assign busy = (st_q != ST_IDLE);
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk #(
    parameter int VA_W = 15
) (
    input logic            clk,
    input logic            rst_n,
    input logic            busy,
    input logic            done,
    input logic [1:0]      fault,
    input logic            mem_rd_en,
    input logic [VA_W-1:0] va_q
);
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> !mem_rd_en);

    p_first_read_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> mem_rd_en);

    p_read_gap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        mem_rd_en |=> !mem_rd_en);

    p_fault_code_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(fault));

    p_done_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);

    p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    p_va_held_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(va_q));
endmodule

bind pt_walker pt_walker_chk #(.VA_W(VA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .done      (done),
    .fault     (fault),
    .mem_rd_en (mem_rd_en),
    .va_q      (va_q)
);

// File: tb/sim_pt_walker.sv
`timescale 1ns/1ps
module sim_pt_walker;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [6:0]  dir_base = '0;
    logic        req_valid = 1'b0;
    logic [14:0] req_vaddr = '0;
    logic        mem_rd_en;
    logic [11:0] mem_addr;
    logic [7:0]  mem_rdata = '0;
    logic        busy, done;
    logic [1:0]  fault;
    logic [11:0] paddr;
    logic [7:0]  rdata;

    logic [7:0] mem [0:4095];

    int checks = 0;
    int failures = 0;

    int          exp_n, exp_lat;
    logic [1:0]  exp_f;
    logic [11:0] exp_pa;
    logic [7:0]  exp_d;
    logic [11:0] exp_a [0:2];

    always #4 clk = ~clk;

    always @(posedge clk) begin
        if (mem_rd_en) mem_rdata <= mem[mem_addr];
    end

    pt_walker u0 (
        .clk(clk), .rst_n(rst_n), .dir_base(dir_base), .req_valid(req_valid),
        .req_vaddr(req_vaddr), .mem_rd_en(mem_rd_en), .mem_addr(mem_addr),
        .mem_rdata(mem_rdata), .busy(busy), .done(done), .fault(fault),
        .paddr(paddr), .rdata(rdata)
    );

    task automatic chk(input logic ok, input string req, input string what,
                       input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Software walk: entry bit 7 valid, bits 6:0 page; codes 00 ok, 01 dir, 10 table.
    task automatic predict(input logic [14:0] va, input logic [6:0] base);
        logic [7:0] pde, pte;
        exp_a[0] = {base, va[14:10]};
        pde = mem[exp_a[0]];
        exp_pa = '0;
        exp_d = '0;
        if (!pde[7]) begin
            exp_f = 2'b01; exp_n = 1; exp_lat = 3;
        end else begin
            exp_a[1] = {pde[6:0], va[9:5]};
            pte = mem[exp_a[1]];
            if (!pte[7]) begin
                exp_f = 2'b10; exp_n = 2; exp_lat = 5;
            end else begin
                exp_a[2] = {pte[6:0], va[4:0]};
                exp_f = 2'b00; exp_n = 3; exp_lat = 7;
                exp_pa = exp_a[2];
                exp_d = mem[exp_a[2]];
            end
        end
    endtask

    task automatic run_walk(input logic [14:0] va, input logic [6:0] base, input bit noise);
        int nr;
        string rq;
        predict(va, base);
        rq = (exp_f == 2'b01) ? "R6" : (exp_f == 2'b10) ? "R7" : "R8";
        @(negedge clk);
        dir_base  = base;
        req_vaddr = va;
        req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        nr = 0;
        for (int k = 1; k <= 9; k++) begin
            if (k > 1) @(negedge clk);
            chk(done === (k == exp_lat), "R9", "done timing", int'(done), int'(k == exp_lat));
            if (k < exp_lat) chk(busy === 1'b1, "R10", "busy during walk", int'(busy), 1);
            if (mem_rd_en) begin
                if (nr < 3) begin
                    chk(mem_addr === exp_a[nr], (nr == 0) ? "R2" : (nr == 1) ? "R4" : "R5",
                        "read address", int'(mem_addr), int'(exp_a[nr]));
                    chk(k == 2 * nr + 1, "R4", "read cycle", k, 2 * nr + 1);
                end
                nr++;
            end
            if (k == exp_lat) begin
                chk(fault === exp_f, rq, "fault", int'(fault), int'(exp_f));
                chk(paddr === exp_pa, "R5", "paddr", int'(paddr), int'(exp_pa));
                chk(rdata === exp_d, "R5", "rdata", int'(rdata), int'(exp_d));
            end
            if (k == 9) begin
                chk(fault === exp_f && paddr === exp_pa && rdata === exp_d, "R11",
                    "result hold", int'(paddr), int'(exp_pa));
            end
            if (noise && k == 2) begin
                req_valid = 1'b1;
                req_vaddr = ~va;
                dir_base  = base ^ 7'h01;
            end
            if (noise && k == 3) req_valid = 1'b0;
        end
        chk(nr == exp_n, rq, "read count", nr, exp_n);
    endtask

    initial begin
        for (int i = 0; i < 4096; i++) mem[i] = 8'($urandom);
        repeat (3) @(negedge clk);
        chk(busy === 1'b0 && done === 1'b0, "R1", "busy/done at reset", int'({busy, done}), 0);
        chk(fault === 2'b00, "R1", "fault at reset", int'(fault), 0);
        chk(mem_rd_en === 1'b0, "R1", "read strobe at reset", int'(mem_rd_en), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy === 1'b0, "R1", "busy after reset", int'(busy), 0);

        // R6: directory entry with bit 7 clear
        mem[{7'd3, 5'd4}] = 8'h15;
        run_walk({5'd4, 5'd9, 5'd2}, 7'd3, 1'b0);
        // R7: valid directory entry, invalid table entry
        mem[{7'd3, 5'd6}] = 8'h80 | 8'd10;
        mem[{7'd10, 5'd12}] = 8'h22;
        run_walk({5'd6, 5'd12, 5'd7}, 7'd3, 1'b0);
        // R3 R8: both valid, known data
        mem[{7'd3, 5'd31}] = 8'h80 | 8'd11;
        mem[{7'd11, 5'd0}] = 8'h80 | 8'h40;
        mem[{7'h40, 5'd31}] = 8'hA5;
        run_walk({5'd31, 5'd0, 5'd31}, 7'd3, 1'b0);
        // R10: same success walk with a competing request mid-walk
        run_walk({5'd31, 5'd0, 5'd31}, 7'd3, 1'b1);
        // Frame 0 and page 0 edge: valid entries pointing at page 0
        mem[{7'd5, 5'd0}] = 8'h80;
        mem[{7'd0, 5'd1}] = 8'h80 | 8'd127;
        run_walk({5'd0, 5'd1, 5'd0}, 7'd5, 1'b1);

        for (int i = 0; i < 60; i++) begin
            run_walk(15'($urandom), 7'($urandom), (i % 2) == 1);
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired actual=0 expected=1");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule